// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Upper-Byte Latches

This block keeps a 21-bit program counter that addresses bytes in program memory. Instructions are two bytes wide, so bit 0 of the counter is always zero and a sequential step adds two. Control-transfer instructions (call, relative call, goto, branch) load a full target address through a dedicated port.

From the data bus, only the low byte of the counter can be reached directly. The middle byte (bits 15:8) and the upper field (bits 20:16) change only through two holding latches:
- A write to the low byte moves both latches into the upper parts of the counter in the same edge.
- A read of the low byte copies the current upper parts back into the latches.

Software uses this pair to compute jump targets and table offsets.

Top module: `pc_latch_counter`

## Requirements
- R1: While reset is low, and on the first edge after it, the counter, the middle latch and the upper latch read as zero.
- R2: Bit 0 of `pcOut` is zero in every cycle.
- R3: A step (`stepEn`) with no load pending adds 2 to the counter on the next edge, wrapping from 0x1FFFFE to 0x000000.
- R4: `lowRdData` always equals bits 7:0 of `pcOut`.
- R5: A low-byte write (`lowWrEn`) with no jump loads bits 7:1 from `dataIn[7:1]`, forces bit 0 to zero, loads bits 15:8 from the middle latch and loads bits 20:16 from the upper latch. The latch values are those held before that edge.
- R6: A low-byte read strobe (`lowRdEn`) copies counter bits 15:8 into the middle latch and bits 20:16 into the upper latch on that edge.
- R7: A jump (`jumpEn`) loads `jumpAddr` with bit 0 cleared, and leaves both latches untouched.
- R8: When several counter updates coincide, a jump wins over a low-byte write, and a low-byte write wins over a step.
- R9: `hiLatWrEn` loads the middle latch from `dataIn`. `upLatWrEn` loads the upper latch from `dataIn[4:0]`. `upLatRd` shows the upper latch in bits 4:0, and its bits 7:5 read as zero.
- R10: An explicit latch write beats the copy from a low-byte read for that same latch in the same cycle.
- R11: Latch writes and low-byte reads leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | Advance to the next instruction word |
| jumpEn | input | 1 | Load the full counter from jumpAddr |
| jumpAddr | input | 21 | Control-transfer target address |
| lowWrEn | input | 1 | Write low byte from dataIn and transfer both latches |
| lowRdEn | input | 1 | Low-byte read strobe; copies the upper parts into the latches |
| hiLatWrEn | input | 1 | Write middle latch from dataIn |
| upLatWrEn | input | 1 | Write upper latch from dataIn[4:0] |
| dataIn | input | 8 | Data bus write value |
| lowRdData | output | 8 | Current low byte of the counter |
| hiLatRd | output | 8 | Middle latch contents |
| upLatRd | output | 8 | Upper latch contents, zero-extended |
| pcOut | output | 21 | Current counter value |

## Verification
A step and a direct load can land on the same edge, either a jump or a low-byte write. A low-byte read can also meet an explicit latch write. The random phase drives every strobe on its own random bit, so all of these coincidences occur many times. Directed cycles also force a jump together with a low write and a step. A bench model applies the priority order from R8 and R10 and predicts the counter and both latches. Each coincident cycle is judged against that model one edge later.

// File: rtl/pc_latch_pkg.sv
package pc_latch_pkg;
  typedef struct packed {
    logic loadJump;
    logic loadLow;
    logic step;
    logic copyLat;
    logic wrHi;
    logic wrUp;
  } pcStrobes_t;
endpackage

// File: rtl/pc_latch_ctrl.sv
module pc_latch_ctrl
  import pc_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepEn,
  input  logic       jumpEn,
  input  logic       lowWrEn,
  input  logic       lowRdEn,
  input  logic       hiLatWrEn,
  input  logic       upLatWrEn,
  output pcStrobes_t ctl
);
  always_comb begin
    ctl.loadJump = jumpEn;
    ctl.loadLow  = lowWrEn && !jumpEn;
    ctl.step     = stepEn && !jumpEn && !lowWrEn;
    ctl.copyLat  = lowRdEn;
    ctl.wrHi     = hiLatWrEn;
    ctl.wrUp     = upLatWrEn;
  end

  // R8
  counter_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadJump, ctl.loadLow, ctl.step}));

  // R8
  jump_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    jumpEn |-> (!ctl.loadLow && !ctl.step));
endmodule

// File: rtl/pc_latch_datapath.sv
module pc_latch_datapath
  import pc_latch_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobes_t        ctl,
  input  logic [PC_W-1:0]   jumpAddr,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [PC_W-1:0]   pcQ,
  output logic [BYTE_W-1:0] hiLatQ,
  output logic [PC_W-2*BYTE_W-1:0] upLatQ
);
  localparam int UP_W   = PC_W - 2*BYTE_W;
  localparam int HI_LSB = BYTE_W;
  localparam int UP_LSB = 2*BYTE_W;

  logic [PC_W-1:0] pcNext;

  always_comb begin
    pcNext = pcQ;
    if (ctl.loadJump)     pcNext = {jumpAddr[PC_W-1:1], 1'b0};
    else if (ctl.loadLow) pcNext = {upLatQ, hiLatQ, dataIn[BYTE_W-1:1], 1'b0};
    else if (ctl.step)    pcNext = pcQ + PC_W'(2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            hiLatQ <= '0;
    else if (ctl.wrHi)    hiLatQ <= dataIn;
    else if (ctl.copyLat) hiLatQ <= pcQ[UP_LSB-1:HI_LSB];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            upLatQ <= '0;
    else if (ctl.wrUp)    upLatQ <= dataIn[UP_W-1:0];
    else if (ctl.copyLat) upLatQ <= pcQ[PC_W-1:UP_LSB];
  end

  // R2
  align_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcQ[0] == 1'b0);

  // R3
  step_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> pcQ == $past(pcQ) + PC_W'(2));

  // R7
  jump_latch_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadJump && !ctl.wrHi && !ctl.copyLat) |=> hiLatQ == $past(hiLatQ));

  // R5
  low_write_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLow |=> (pcQ[UP_LSB-1:HI_LSB] == $past(hiLatQ)) &&
                    (pcQ[PC_W-1:UP_LSB] == $past(upLatQ)));

  // R6
  read_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.copyLat && !ctl.wrHi) |=> hiLatQ == $past(pcQ[UP_LSB-1:HI_LSB]));

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadJump || ctl.loadLow || ctl.step) |=> $stable(pcQ));
endmodule

// File: rtl/pc_latch_counter.sv
module pc_latch_counter
  import pc_latch_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              jumpEn,
  input  logic [PC_W-1:0]   jumpAddr,
  input  logic              lowWrEn,
  input  logic              lowRdEn,
  input  logic              hiLatWrEn,
  input  logic              upLatWrEn,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [BYTE_W-1:0] lowRdData,
  output logic [BYTE_W-1:0] hiLatRd,
  output logic [BYTE_W-1:0] upLatRd,
  output logic [PC_W-1:0]   pcOut
);
  localparam int UP_W = PC_W - 2*BYTE_W;

  pcStrobes_t        ctl;
  logic [PC_W-1:0]   pcQ;
  logic [BYTE_W-1:0] hiLatQ;
  logic [UP_W-1:0]   upLatQ;

  pc_latch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .jumpEn(jumpEn),
    .lowWrEn(lowWrEn), .lowRdEn(lowRdEn), .hiLatWrEn(hiLatWrEn),
    .upLatWrEn(upLatWrEn), .ctl(ctl)
  );

  pc_latch_datapath #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .jumpAddr(jumpAddr),
    .dataIn(dataIn), .pcQ(pcQ), .hiLatQ(hiLatQ), .upLatQ(upLatQ)
  );

  assign pcOut     = pcQ;
  assign lowRdData = pcQ[BYTE_W-1:0];
  assign hiLatRd   = hiLatQ;
  assign upLatRd   = {{(BYTE_W-UP_W){1'b0}}, upLatQ};

  // R4
  low_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowRdData == pcOut[BYTE_W-1:0]);

  // R9
  up_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    upLatRd[BYTE_W-1:UP_W] == '0);
endmodule

// File: tb/tb_pc_latch_counter.sv
module tb_pc_latch_counter;
  logic        clk = 1'b0;
  logic        rstN;
  logic        stepEn, jumpEn, lowWrEn, lowRdEn, hiLatWrEn, upLatWrEn;
  logic [20:0] jumpAddr;
  logic [7:0]  dataIn;
  logic [7:0]  lowRdData, hiLatRd, upLatRd;
  logic [20:0] pcOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [20:0] mPc;
  logic [7:0]  mHi;
  logic [4:0]  mUp;

  always #4 clk = ~clk;

  pc_latch_counter dut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .jumpEn(jumpEn),
    .jumpAddr(jumpAddr), .lowWrEn(lowWrEn), .lowRdEn(lowRdEn),
    .hiLatWrEn(hiLatWrEn), .upLatWrEn(upLatWrEn), .dataIn(dataIn),
    .lowRdData(lowRdData), .hiLatRd(hiLatRd), .upLatRd(upLatRd),
    .pcOut(pcOut)
  );

  function automatic logic [20:0] nextPc(logic [20:0] pc, logic [7:0] hi, logic [4:0] up,
                                         logic j, logic [20:0] a, logic w, logic s, logic [7:0] d);
    if (j)      return {a[20:1], 1'b0};
    else if (w) return {up, hi, d[7:1], 1'b0};
    else if (s) return pc + 21'd2;
    return pc;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    stepEn = 0; jumpEn = 0; lowWrEn = 0; lowRdEn = 0;
    hiLatWrEn = 0; upLatWrEn = 0; jumpAddr = '0; dataIn = '0;
  endtask

  task automatic cycle(logic s, logic j, logic [20:0] a, logic w, logic r,
                       logic hw, logic uw, logic [7:0] d);
    logic [20:0] ePc;
    logic [7:0]  eHi;
    logic [4:0]  eUp;
    string tag;
    stepEn = s; jumpEn = j; jumpAddr = a; lowWrEn = w; lowRdEn = r;
    hiLatWrEn = hw; upLatWrEn = uw; dataIn = d;
    ePc = nextPc(mPc, mHi, mUp, j, a, w, s, d);
    eHi = hw ? d : (r ? mPc[15:8] : mHi);
    eUp = uw ? d[4:0] : (r ? mPc[20:16] : mUp);
    if (j && (w || s))        tag = "R8";
    else if (j)               tag = "R7";
    else if (w)               tag = (s ? "R8" : "R5");
    else if (s)               tag = "R3";
    else                      tag = "R11";
    @(posedge clk);
    @(negedge clk);
    mPc = ePc; mHi = eHi; mUp = eUp;
    check(tag, 32'(pcOut), 32'(ePc));
    check((r && (hw || uw)) ? "R10" : (r ? "R6" : "R9"), 32'(hiLatRd), 32'(eHi));
    check((r && (hw || uw)) ? "R10" : (r ? "R6" : "R9"), 32'(upLatRd), 32'({3'b000, eUp}));
    check("R4", 32'(lowRdData), 32'(ePc[7:0]));
    check("R2", 32'(pcOut[0]), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rstN = 1'b0;
    mPc = '0; mHi = '0; mUp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(pcOut), 32'd0);
    check("R1", 32'(hiLatRd), 32'd0);
    check("R1", 32'(upLatRd), 32'd0);
    rstN = 1'b1;
    cycle(0, 0, '0, 0, 0, 0, 0, 8'h00);
    check("R1", 32'(pcOut), 32'd0);

    // R3 wrap at the top of the space
    cycle(0, 1, 21'h1FFFFF, 0, 0, 0, 0, 8'h00);
    cycle(1, 0, '0, 0, 0, 0, 0, 8'h00);
    check("R3", 32'(pcOut), 32'd0);

    // R9 upper latch keeps five bits only
    cycle(0, 0, '0, 0, 0, 1, 1, 8'hFF);
    check("R9", 32'(upLatRd), 32'h1F);

    // R5 odd data on a low write still gives bit 0 zero, latches transferred
    cycle(0, 0, '0, 0, 0, 1, 1, 8'hA5);
    cycle(0, 0, '0, 1, 0, 0, 0, 8'h37);
    check("R5", 32'(pcOut), 32'h05A536);

    // R6 low read copies upper parts back
    cycle(0, 1, 21'h12_3456, 0, 0, 0, 0, 8'h00);
    cycle(0, 0, '0, 0, 1, 0, 0, 8'h00);
    check("R6", 32'(hiLatRd), 32'h34);
    check("R6", 32'(upLatRd), 32'h12);

    // R8 all three counter updates together
    cycle(1, 1, 21'h0ABCDE, 1, 0, 0, 0, 8'h11);
    check("R8", 32'(pcOut), 32'h0ABCDE);
    cycle(1, 0, '0, 1, 0, 0, 0, 8'h11);
    check("R8", 32'(pcOut), 32'h123410);

    // R10 explicit write beats read copy
    cycle(0, 0, '0, 0, 1, 1, 1, 8'h0E);
    check("R10", 32'(hiLatRd), 32'h0E);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom();
      cycle(rv[0] | rv[1], rv[2] & rv[3] & rv[4], 21'($urandom()),
            rv[5] & rv[6], rv[7] & rv[8], rv[9] & rv[10], rv[11] & rv[12],
            8'($urandom()));
    end

    idle();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule